// File: doc/BRIEF.md
# SPI Receive Data Capture Unit

This block sits between an SPI shifter and the host-visible receive data register. The shifter hands it one received byte per valid cycle, each tagged with the frame segment it came from. Each segment has its own receive enable. A byte is only taken into the 64-bit holding register when its segment is enabled. Every kept byte moves the register contents up by one byte and lands in the lowest byte lane.

When the two-bit ECC control input selects an ECC-carrying mode, the unit counts the enabled bytes of the current frame. Every ninth byte is treated as a check byte and thrown away, and the count starts again. At the end of a frame that carried enabled bytes, the unit sets a full flag. If the host has not yet taken the previous data, it sets an overrun flag instead. A host read of the register clears the full flag. A host status write loads the overrun flag from the written bit.

For a sequencer that branches on received data, the unit compares the low 16 bits of the register against a configured value under a configured mask. Mask bits of 1 mean "ignore". The unit also signals the sequencer to resume when the host drains the register while the sequencer is waiting.

Top module: `spirx_capture_top`

## Requirements
- R1: While reset is asserted and directly after it, `rdr_o` is zero and `full_o`, `overrun_o` and `resume_o` are low; the ECC byte count is zero.
- R2: Each loaded byte shifts `rdr_o` left by 8 bits and places the byte in `rdr_o[7:0]`. The change is visible in the cycle after the byte's clock edge.
- R3: A byte with `byte_seg_i`=0 is loaded only if `seg1_rx_en_i` is 1, and a byte with `byte_seg_i`=1 only if `seg2_rx_en_i` is 1. Bytes of a disabled segment leave `rdr_o` unchanged and do not advance the ECC count.
- R4: With `ecc_ctrl_i` equal to 2'b00 or 2'b10, the ninth enabled byte since the count last restarted is discarded and the count returns to zero. With 2'b01 or 2'b11, every enabled byte is loaded.
- R5: A `frame_start_i` pulse restarts the ECC count. A byte arriving in the same cycle counts as the first of the new frame.
- R6: On `frame_end_i`, if at least one enabled byte arrived since the frame began (the end cycle included), `full_o` is set. If `full_o` was already 1, `overrun_o` is also set. A frame without enabled bytes changes neither flag.
- R7: `host_rd_i` clears `full_o` on the next cycle, unless a frame end in the same cycle sets it.
- R8: `host_wr_i` loads `overrun_o` from `host_wr_ovr_i`. A frame-end overrun in the same cycle takes precedence and leaves the flag set.
- R9: `match_o` is 1 exactly when every bit position with `match_mask_i`=0 has equal bits in `match_val_i` and `rdr_o[15:0]`. An all-ones mask always matches.
- R10: `resume_o` pulses high for one cycle in the cycle after `host_rd_i` is sampled while `wait_i` is high. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid_i | input | 1 | A received byte is present |
| byte_data_i | input | 8 | Received byte |
| byte_seg_i | input | 1 | Segment tag: 0 first, 1 second |
| frame_start_i | input | 1 | First cycle of a frame |
| frame_end_i | input | 1 | Last cycle of a frame |
| seg1_rx_en_i | input | 1 | Receive enable of the first segment |
| seg2_rx_en_i | input | 1 | Receive enable of the second segment |
| ecc_ctrl_i | input | 2 | ECC control; bit 0 low selects check-byte dropping |
| host_rd_i | input | 1 | Host read strobe of the data register |
| host_wr_i | input | 1 | Host write strobe of the status register |
| host_wr_ovr_i | input | 1 | Overrun bit of the host status write |
| wait_i | input | 1 | Sequencer is waiting for the register to drain |
| match_mask_i | input | 16 | Compare mask, 1 ignores a bit |
| match_val_i | input | 16 | Compare value |
| rdr_o | output | 64 | Receive data register |
| full_o | output | 1 | Register holds unread data |
| overrun_o | output | 1 | Unread data was overwritten by a frame |
| match_o | output | 1 | Masked 16-bit compare result |
| resume_o | output | 1 | One-cycle resume pulse for the sequencer |

## Verification
The checks assume that the inputs are held at zero during reset. They also assume that every input changes only between clock edges, so each sampled value is the one driven for that cycle. The flag properties also assume that `frame_end_i` is the only source of a rising full flag. They accept either an earlier full flag or a host write of 1 as the cause of a rising overrun flag. The stimulus drives every input a fixed delay after the rising edge and clears all pulses after one cycle. It combines directed frames with free random traffic, including simultaneous frame ends, reads and writes. These combinations stay inside what the assumptions allow.

// File: rtl/spirx_pkg.sv
package spirx_pkg;

    localparam int unsigned SPIRX_BYTE_W = 8;

    // Bit 0 of the ECC control clear means check bytes ride in the stream.
    function automatic logic spirx_ecc_drops(input logic [1:0] ctrl);
        return ~ctrl[0];
    endfunction

    typedef struct packed {
        logic full;
        logic overrun;
        logic seen;
        logic resume;
    } spirx_stat_t;

endpackage

// File: rtl/spirx_ecc_filter.sv
module spirx_ecc_filter #(
    parameter int unsigned GROUP_LEN = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start_i,
    input  logic       byte_en_i,
    input  logic [1:0] ecc_ctrl_i,
    output logic       load_o
);
    import spirx_pkg::*;

    localparam int unsigned CNT_W = $clog2(GROUP_LEN + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } filt_t;

    filt_t filt_d, filt_q;
    logic [CNT_W-1:0] base_cnt;

    always_comb begin
        base_cnt   = frame_start_i ? '0 : filt_q.cnt;
        filt_d.cnt = base_cnt;
        load_o     = 1'b0;
        if (byte_en_i) begin
            if (spirx_ecc_drops(ecc_ctrl_i)) begin
                if (base_cnt == CNT_W'(GROUP_LEN - 1)) begin
                    filt_d.cnt = '0;
                end else begin
                    filt_d.cnt = base_cnt + CNT_W'(1);
                    load_o     = 1'b1;
                end
            end else begin
                filt_d.cnt = '0;
                load_o     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) filt_q <= '0;
        else        filt_q <= filt_d;
    end

endmodule

// File: rtl/spirx_shift_reg.sv
module spirx_shift_reg #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [DATA_W-1:0] rdr_o
);
    localparam int unsigned KEEP_W = DATA_W - BYTE_W;

    logic [DATA_W-1:0] rdr_d, rdr_q;

    always_comb begin
        rdr_d = rdr_q;
        if (load_i) rdr_d = {rdr_q[KEEP_W-1:0], data_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdr_q <= '0;
        else        rdr_q <= rdr_d;
    end

    assign rdr_o = rdr_q;

endmodule

// File: rtl/spirx_status.sv
module spirx_status (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_en_i,
    input  logic frame_start_i,
    input  logic frame_end_i,
    input  logic host_rd_i,
    input  logic host_wr_i,
    input  logic host_wr_ovr_i,
    input  logic wait_i,
    output logic full_o,
    output logic overrun_o,
    output logic resume_o
);
    import spirx_pkg::*;

    spirx_stat_t st_d, st_q;
    logic seen_now;
    logic frame_hit;

    always_comb begin
        seen_now  = (frame_start_i ? 1'b0 : st_q.seen) | byte_en_i;
        frame_hit = frame_end_i & seen_now;
        st_d      = st_q;

        st_d.seen = frame_end_i ? 1'b0 : seen_now;

        if (frame_hit)      st_d.full = 1'b1;
        else if (host_rd_i) st_d.full = 1'b0;

        if (frame_hit && st_q.full) st_d.overrun = 1'b1;
        else if (host_wr_i)         st_d.overrun = host_wr_ovr_i;

        st_d.resume = host_rd_i & wait_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full_o    = st_q.full;
    assign overrun_o = st_q.overrun;
    assign resume_o  = st_q.resume;

endmodule

// File: rtl/spirx_match.sv
module spirx_match #(
    parameter int unsigned MATCH_W = 16
) (
    input  logic [MATCH_W-1:0] data_i,
    input  logic [MATCH_W-1:0] mask_i,
    input  logic [MATCH_W-1:0] value_i,
    output logic               match_o
);
    logic [MATCH_W-1:0] bit_ok;

    for (genvar i = 0; i < MATCH_W; i++) begin : g_bit
        assign bit_ok[i] = mask_i[i] | ~(data_i[i] ^ value_i[i]);
    end

    assign match_o = &bit_ok;

endmodule

// File: rtl/spirx_capture_top.sv
module spirx_capture_top #(
    parameter int unsigned DATA_W    = 64,
    parameter int unsigned MATCH_W   = 16,
    parameter int unsigned GROUP_LEN = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_valid_i,
    input  logic [7:0]         byte_data_i,
    input  logic               byte_seg_i,
    input  logic               frame_start_i,
    input  logic               frame_end_i,
    input  logic               seg1_rx_en_i,
    input  logic               seg2_rx_en_i,
    input  logic [1:0]         ecc_ctrl_i,
    input  logic               host_rd_i,
    input  logic               host_wr_i,
    input  logic               host_wr_ovr_i,
    input  logic               wait_i,
    input  logic [MATCH_W-1:0] match_mask_i,
    input  logic [MATCH_W-1:0] match_val_i,
    output logic [DATA_W-1:0]  rdr_o,
    output logic               full_o,
    output logic               overrun_o,
    output logic               match_o,
    output logic               resume_o
);
    import spirx_pkg::*;

    logic byte_en;
    logic load;

    assign byte_en = byte_valid_i & (byte_seg_i ? seg2_rx_en_i : seg1_rx_en_i);

    spirx_ecc_filter #(.GROUP_LEN(GROUP_LEN)) u_filter (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start_i),
        .byte_en_i     (byte_en),
        .ecc_ctrl_i    (ecc_ctrl_i),
        .load_o        (load)
    );

    spirx_shift_reg #(.DATA_W(DATA_W), .BYTE_W(SPIRX_BYTE_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .data_i (byte_data_i),
        .rdr_o  (rdr_o)
    );

    spirx_status u_status (
        .clk           (clk),
        .rst_n         (rst_n),
        .byte_en_i     (byte_en),
        .frame_start_i (frame_start_i),
        .frame_end_i   (frame_end_i),
        .host_rd_i     (host_rd_i),
        .host_wr_i     (host_wr_i),
        .host_wr_ovr_i (host_wr_ovr_i),
        .wait_i        (wait_i),
        .full_o        (full_o),
        .overrun_o     (overrun_o),
        .resume_o      (resume_o)
    );

    spirx_match #(.MATCH_W(MATCH_W)) u_match (
        .data_i  (rdr_o[MATCH_W-1:0]),
        .mask_i  (match_mask_i),
        .value_i (match_val_i),
        .match_o (match_o)
    );

endmodule

// File: rtl/spirx_capture_chk.sv
module spirx_capture_chk #(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned MATCH_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               byte_valid_i,
    input logic               frame_end_i,
    input logic               host_rd_i,
    input logic               host_wr_i,
    input logic               host_wr_ovr_i,
    input logic               wait_i,
    input logic [MATCH_W-1:0] match_mask_i,
    input logic [DATA_W-1:0]  rdr_o,
    input logic               full_o,
    input logic               overrun_o,
    input logic               match_o,
    input logic               resume_o
);
    assert_rdr_needs_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rdr_o) |-> $past(byte_valid_i));

    assert_full_from_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_o) |-> $past(frame_end_i));

    assert_full_clear_by_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full_o) |-> $past(host_rd_i));

    assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> ($past(full_o) || $past(host_wr_i && host_wr_ovr_i)));

    assert_mask_all_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (&match_mask_i) |-> match_o);

    assert_resume_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> $past(host_rd_i && wait_i));

endmodule

bind spirx_capture_top spirx_capture_chk #(.DATA_W(DATA_W), .MATCH_W(MATCH_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .byte_valid_i  (byte_valid_i),
    .frame_end_i   (frame_end_i),
    .host_rd_i     (host_rd_i),
    .host_wr_i     (host_wr_i),
    .host_wr_ovr_i (host_wr_ovr_i),
    .wait_i        (wait_i),
    .match_mask_i  (match_mask_i),
    .rdr_o         (rdr_o),
    .full_o        (full_o),
    .overrun_o     (overrun_o),
    .match_o       (match_o),
    .resume_o      (resume_o)
);

// File: tb/spirx_capture_tb.sv
module spirx_capture_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_valid_i = 1'b0;
    logic [7:0]  byte_data_i = '0;
    logic        byte_seg_i = 1'b0;
    logic        frame_start_i = 1'b0;
    logic        frame_end_i = 1'b0;
    logic        seg1_rx_en_i = 1'b0;
    logic        seg2_rx_en_i = 1'b0;
    logic [1:0]  ecc_ctrl_i = 2'b01;
    logic        host_rd_i = 1'b0;
    logic        host_wr_i = 1'b0;
    logic        host_wr_ovr_i = 1'b0;
    logic        wait_i = 1'b0;
    logic [15:0] match_mask_i = 16'hFFFF;
    logic [15:0] match_val_i = '0;
    logic [63:0] rdr_o;
    logic        full_o, overrun_o, match_o, resume_o;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    spirx_capture_top dut_i (
        .clk(clk), .rst_n(rst_n), .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
        .byte_seg_i(byte_seg_i), .frame_start_i(frame_start_i), .frame_end_i(frame_end_i),
        .seg1_rx_en_i(seg1_rx_en_i), .seg2_rx_en_i(seg2_rx_en_i), .ecc_ctrl_i(ecc_ctrl_i),
        .host_rd_i(host_rd_i), .host_wr_i(host_wr_i), .host_wr_ovr_i(host_wr_ovr_i),
        .wait_i(wait_i), .match_mask_i(match_mask_i), .match_val_i(match_val_i),
        .rdr_o(rdr_o), .full_o(full_o), .overrun_o(overrun_o), .match_o(match_o),
        .resume_o(resume_o)
    );

    // Behavioural reference model
    logic [63:0] m_rdr = '0;
    int          m_cnt = 0;
    bit          m_seen = 0, m_full = 0, m_ovr = 0, m_resume = 0;

    always @(posedge clk) begin : model
        bit en, keep, seen_now, hit;
        int start;
        if (!rst_n) begin
            m_rdr = '0; m_cnt = 0; m_seen = 0; m_full = 0; m_ovr = 0; m_resume = 0;
        end else begin
            en    = byte_valid_i && (byte_seg_i ? seg2_rx_en_i : seg1_rx_en_i);
            start = frame_start_i ? 0 : m_cnt;
            keep  = 0;
            if (en) begin
                if (ecc_ctrl_i == 2'b00 || ecc_ctrl_i == 2'b10) begin
                    if (start + 1 == 9) m_cnt = 0;
                    else begin m_cnt = start + 1; keep = 1; end
                end else begin
                    m_cnt = 0; keep = 1;
                end
            end else m_cnt = start;
            if (keep) m_rdr = (m_rdr << 8) | 64'(byte_data_i);
            seen_now = (frame_start_i ? 1'b0 : m_seen) || en;
            hit = frame_end_i && seen_now;
            m_seen = frame_end_i ? 1'b0 : seen_now;
            if (hit && m_full) m_ovr = 1;
            else if (host_wr_i) m_ovr = host_wr_ovr_i;
            if (hit) m_full = 1;
            else if (host_rd_i) m_full = 0;
            m_resume = host_rd_i && wait_i;
        end
    end

    always @(negedge clk) begin : compare
        bit exp_match;
        exp_match = ((~match_mask_i & match_val_i) == (~match_mask_i & m_rdr[15:0]));
        n_cmp++;
        if (rdr_o !== m_rdr) begin
            n_bad++; $display("FAIL %s rdr actual %h expected %h", cur_req, rdr_o, m_rdr);
        end
        n_cmp++;
        if (full_o !== m_full) begin
            n_bad++; $display("FAIL %s full actual %b expected %b", cur_req, full_o, m_full);
        end
        n_cmp++;
        if (overrun_o !== m_ovr) begin
            n_bad++; $display("FAIL %s overrun actual %b expected %b", cur_req, overrun_o, m_ovr);
        end
        n_cmp++;
        if (match_o !== exp_match) begin
            n_bad++; $display("FAIL R9 match actual %b expected %b", match_o, exp_match);
        end
        n_cmp++;
        if (resume_o !== m_resume) begin
            n_bad++; $display("FAIL R10 resume actual %b expected %b", resume_o, m_resume);
        end
    end

    task automatic cyc();
        @(posedge clk); #2;
        byte_valid_i = 0; frame_start_i = 0; frame_end_i = 0;
        host_rd_i = 0; host_wr_i = 0; host_wr_ovr_i = 0;
    endtask

    task automatic send(input bit seg, input logic [7:0] d, input bit fs, input bit fe);
        byte_valid_i = 1; byte_seg_i = seg; byte_data_i = d;
        frame_start_i = fs; frame_end_i = fe;
        cyc();
    endtask

    task automatic frame(input int n, input bit seg, input logic [7:0] seed);
        for (int i = 0; i < n; i++) send(seg, seed + 8'(i), i == 0, i == n - 1);
    endtask

    task automatic rd(input bit w);
        wait_i = w; host_rd_i = 1; cyc(); wait_i = 0;
    endtask

    task automatic wr(input bit v);
        host_wr_i = 1; host_wr_ovr_i = v; cyc();
    endtask

    bit done = 0;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        cur_req = "R1";
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        cyc(); cyc();

        cur_req = "R2";
        seg1_rx_en_i = 1; ecc_ctrl_i = 2'b01;
        frame(10, 0, 8'h10);
        cyc();

        cur_req = "R7";
        rd(0); cyc();

        cur_req = "R6";
        frame(3, 0, 8'hA0);
        frame(2, 0, 8'hB0);
        cyc();
        seg1_rx_en_i = 0;
        frame(4, 0, 8'hC0);

        cur_req = "R8";
        wr(0); wr(1); wr(0);

        cur_req = "R3";
        rd(0);
        seg1_rx_en_i = 0; seg2_rx_en_i = 1;
        for (int i = 0; i < 6; i++) send(i[0], 8'h50 + 8'(i), i == 0, i == 5);
        seg1_rx_en_i = 1; seg2_rx_en_i = 0;
        for (int i = 0; i < 6; i++) send(i[0], 8'h60 + 8'(i), i == 0, i == 5);
        rd(0);

        cur_req = "R4";
        seg1_rx_en_i = 1; seg2_rx_en_i = 1;
        ecc_ctrl_i = 2'b00; frame(20, 0, 8'h01); rd(0);
        ecc_ctrl_i = 2'b10;
        for (int i = 0; i < 19; i++) send(i >= 9, 8'h80 + 8'(i), i == 0, i == 18);
        rd(0);
        ecc_ctrl_i = 2'b11; frame(12, 1, 8'hE0); rd(0);

        cur_req = "R5";
        ecc_ctrl_i = 2'b00;
        for (int i = 0; i < 6; i++) send(0, 8'h30 + 8'(i), i == 0, 0);
        for (int i = 0; i < 10; i++) send(0, 8'h40 + 8'(i), i == 0, i == 9);
        rd(0);

        cur_req = "R9";
        match_mask_i = 16'h0000; match_val_i = rdr_o[15:0]; cyc();
        match_val_i = rdr_o[15:0] ^ 16'h0100; cyc();
        match_mask_i = 16'h0100; cyc();
        match_mask_i = 16'hFF00; match_val_i = 16'h1234; cyc();
        match_mask_i = 16'h00FF; cyc();

        cur_req = "R10";
        rd(1); rd(0); rd(1); rd(1); wait_i = 1; cyc(); wait_i = 0;

        cur_req = "R6/R7/R8";
        for (int i = 0; i < 3000; i++) begin
            byte_valid_i  = $urandom_range(0, 3) != 0;
            byte_data_i   = 8'($urandom);
            byte_seg_i    = 1'($urandom);
            frame_start_i = $urandom_range(0, 11) == 0;
            frame_end_i   = $urandom_range(0, 11) == 0;
            seg1_rx_en_i  = $urandom_range(0, 3) != 0;
            seg2_rx_en_i  = $urandom_range(0, 3) != 0;
            if ($urandom_range(0, 40) == 0) ecc_ctrl_i = 2'($urandom);
            host_rd_i     = $urandom_range(0, 7) == 0;
            host_wr_i     = $urandom_range(0, 15) == 0;
            host_wr_ovr_i = 1'($urandom);
            wait_i        = 1'($urandom);
            match_mask_i  = 16'($urandom) & 16'($urandom);
            match_val_i   = 16'($urandom);
            cyc();
        end
        wait_i = 0;
        cyc(); cyc();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule